// File: doc/BRIEF.md
# Single-Line NMI Trigger Controller

This block watches one external non-maskable interrupt line and turns it into a registered interrupt request for a processor. Software reaches three registers over a simple register bus: an address, write data and a write strobe, with read data returned combinationally for the address presented. The registers are a control word, a pending flag and an enable flag.

The line first passes through a two-flop synchroniser. Events are then detected according to a 2-bit trigger type held in the low bits of the control word: active-low level, falling edge, active-high level or rising edge. An event sets the pending flag. Software clears the flag by writing one to it. The outgoing request is the pending flag ANDed with the enable flag, and it is registered.

A parameter chooses where the pending and enable registers sit in the address map. Three layouts are available, so one RTL block can serve drivers written for different maps. The control word is always at offset 0x00. The usual bring-up sequence is to write 0 to enable and then write 1 to pending, which discards any stale event.

Top module: `nmi_trigger_ctrl`

## Requirements
- R1: After reset the control word, the pending flag, the enable flag and `irq_out` are all 0. The synchroniser and the edge history reset to the idle-high line level, so a high line raises no event.
- R2: A write to offset 0x00 stores the whole `DATA_W`-bit word, and a read of 0x00 returns it unchanged. Bits [1:0] are the trigger type: 0 is low level, 1 is falling edge, 2 is high level, 3 is rising edge.
- R3: A change on `line_in` is seen after two synchroniser flops. The pending flag shows the event at the third rising clock edge after the change, and not before.
- R4: With type 0, pending is set on every cycle in which the synchronised line is low. A high line sets nothing.
- R5: With type 1, only a synchronised high-to-low transition sets pending. The flag stays set after the line returns high, and a low-to-high transition sets nothing.
- R6: With type 2, pending is set on every cycle in which the synchronised line is high.
- R7: With type 3, only a synchronised low-to-high transition sets pending.
- R8: A write to the pending offset with data bit 0 = 1 clears pending at that edge, and a clear wins over an event detected in the same cycle. A write with bit 0 = 0 leaves pending unchanged. In a level mode, a level that is still active sets pending again on the next edge.
- R9: Enable bit 0 gates the output. `irq_out` equals pending AND enable as registered one cycle earlier. Clearing enable drops `irq_out` and keeps pending set. Pending and enable both read back in bit 0, with the upper bits reading as 0.
- R10: `LAYOUT` selects the offsets. With 0, pending is at 0x04 and enable at 0x08. With 1, enable is at 0x04 and pending at 0x08. With 2, pending is at 0x04 and enable at 0x34.
- R11: Reads of any other offset return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Asynchronous external interrupt line |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write strobe; the write takes effect at the rising edge |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach from the ports is an acknowledge write landing on exactly the clock edge at which a newly detected edge event would set pending. That is the only situation in which the clear-over-set priority can be seen. The stimulus gets there by counting the synchroniser latency: it moves the line, waits two falling clock edges and then issues the write-one-to-clear, so the write and the event meet on the third rising edge. Checking the other layouts needs two further instances. They share the bus with the main instance, and the bench compares how each one maps the same offsets.

// File: rtl/nmi_trig_pkg.sv
package nmi_trig_pkg;

  typedef enum logic [1:0] {
    TRIG_LVL_LO    = 2'd0,
    TRIG_EDGE_FALL = 2'd1,
    TRIG_LVL_HI    = 2'd2,
    TRIG_EDGE_RISE = 2'd3
  } trig_e;

  localparam int LAYOUT_SEQ    = 0;
  localparam int LAYOUT_SWAP   = 1;
  localparam int LAYOUT_LEGACY = 2;

  localparam int CTRL_OFFSET = 'h00;

  function automatic int pend_offset(input int layout);
    return (layout == LAYOUT_SWAP) ? 'h08 : 'h04;
  endfunction

  function automatic int en_offset(input int layout);
    case (layout)
      LAYOUT_SEQ:  return 'h08;
      LAYOUT_SWAP: return 'h04;
      default:     return 'h34;
    endcase
  endfunction

endpackage

// File: rtl/nmi_sync.sv
module nmi_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES:0] chain;

  assign chain[0] = din;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g+1] <= RST_VAL;
        else        chain[g+1] <= chain[g];
      end
    end
  endgenerate

  assign dout = chain[STAGES];

endmodule

// File: rtl/nmi_detect.sv
module nmi_detect
  import nmi_trig_pkg::*;
#(
  parameter logic RST_VAL = 1'b1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sample,
  input  trig_e trig,
  output logic  event_o
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= sample;
  end

  always_comb begin
    case (trig)
      TRIG_LVL_LO:    event_o = ~sample;
      TRIG_EDGE_FALL: event_o = prev_q & ~sample;
      TRIG_LVL_HI:    event_o = sample;
      TRIG_EDGE_RISE: event_o = ~prev_q & sample;
      default:        event_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/nmi_regs.sv
module nmi_regs
  import nmi_trig_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int LAYOUT = LAYOUT_SEQ
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              event_i,
  output trig_e             trig,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              pend_q,
  output logic              en_q
);

  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFFSET);
  localparam logic [ADDR_W-1:0] PEND_A = ADDR_W'(pend_offset(LAYOUT));
  localparam logic [ADDR_W-1:0] EN_A   = ADDR_W'(en_offset(LAYOUT));

  logic sel_ctrl, sel_pend, sel_en, pend_clr;

  assign sel_ctrl = (bus_addr == CTRL_A);
  assign sel_pend = (bus_addr == PEND_A);
  assign sel_en   = (bus_addr == EN_A);
  assign pend_clr = bus_we & sel_pend & bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 ctrl_q <= '0;
    else if (bus_we && sel_ctrl) ctrl_q <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (pend_clr) pend_q <= 1'b0;
    else if (event_i)  pend_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               en_q <= 1'b0;
    else if (bus_we && sel_en) en_q <= bus_wdata[0];
  end

  assign trig = trig_e'(ctrl_q[1:0]);

  always_comb begin
    if (sel_ctrl)      bus_rdata = ctrl_q;
    else if (sel_pend) bus_rdata = {{(DATA_W-1){1'b0}}, pend_q};
    else if (sel_en)   bus_rdata = {{(DATA_W-1){1'b0}}, en_q};
    else               bus_rdata = '0;
  end

endmodule

// File: rtl/nmi_trigger_ctrl.sv
module nmi_trigger_ctrl
  import nmi_trig_pkg::*;
#(
  parameter int   ADDR_W      = 8,
  parameter int   DATA_W      = 32,
  parameter int   LAYOUT      = LAYOUT_SEQ,
  parameter int   SYNC_STAGES = 2,
  parameter logic IDLE_LEVEL  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_out
);

  logic              line_s;
  logic              event_w;
  trig_e             trig_w;
  logic [DATA_W-1:0] ctrl_w;
  logic              pend_w;
  logic              en_w;

  nmi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(IDLE_LEVEL)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (line_in),
    .dout (line_s)
  );

  nmi_detect #(.RST_VAL(IDLE_LEVEL)) u_detect (
    .clk    (clk),
    .rst_n  (rst_n),
    .sample (line_s),
    .trig   (trig_w),
    .event_o(event_w)
  );

  nmi_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LAYOUT(LAYOUT)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_we   (bus_we),
    .bus_rdata(bus_rdata),
    .event_i  (event_w),
    .trig     (trig_w),
    .ctrl_q   (ctrl_w),
    .pend_q   (pend_w),
    .en_q     (en_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_out <= 1'b0;
    else        irq_out <= pend_w & en_w;
  end

endmodule

// File: rtl/nmi_trigger_ctrl_chk.sv
module nmi_trigger_ctrl_chk
  import nmi_trig_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int LAYOUT = LAYOUT_SEQ
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [DATA_W-1:0] ctrl_q,
  input logic              pend_q,
  input logic              en_q,
  input logic              irq_out
);

  localparam logic [ADDR_W-1:0] C_A = ADDR_W'(CTRL_OFFSET);
  localparam logic [ADDR_W-1:0] P_A = ADDR_W'(pend_offset(LAYOUT));
  localparam logic [ADDR_W-1:0] E_A = ADDR_W'(en_offset(LAYOUT));

  logic unmapped, clr_req;
  assign unmapped = (bus_addr != C_A) && (bus_addr != P_A) && (bus_addr != E_A);
  assign clr_req  = bus_we && (bus_addr == P_A) && bus_wdata[0];

  p_ctrl_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == C_A) |=> (ctrl_q == $past(bus_wdata)));

  p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> !pend_q);

  p_pend_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !clr_req) |=> pend_q);

  p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_out == $past(pend_q && en_q)));

  p_mask_keeps_pend_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == E_A && !bus_wdata[0] && pend_q && !clr_req) |=> (pend_q && !en_q));

  p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped |-> (bus_rdata == '0));

  p_unmapped_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && unmapped) |=> ($stable(ctrl_q) && $stable(en_q)));

endmodule

bind nmi_trigger_ctrl nmi_trigger_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LAYOUT(LAYOUT)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .bus_we   (bus_we),
  .bus_rdata(bus_rdata),
  .ctrl_q   (ctrl_w),
  .pend_q   (pend_w),
  .en_q     (en_w),
  .irq_out  (irq_out)
);

// File: tb/tb_nmi_trigger_ctrl.sv
module tb_nmi_trigger_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        line_in;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_we;
  logic [31:0] rdata_a, rdata_b, rdata_c;
  logic        irq_a, irq_b, irq_c;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  nmi_trigger_ctrl #(.LAYOUT(0)) dut (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(rdata_a), .irq_out(irq_a));

  nmi_trigger_ctrl #(.LAYOUT(1)) dut_swap (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(rdata_b), .irq_out(irq_b));

  nmi_trigger_ctrl #(.LAYOUT(2)) dut_legacy (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(rdata_c), .irq_out(irq_c));

  // behavioural reference of the main instance (pending at 0x04, enable at 0x08)
  bit          m_ff1, m_s, m_sd, m_pend, m_en, m_irq;
  bit [31:0]   m_ctrl;

  function automatic bit m_event();
    case (m_ctrl[1:0])
      2'd0:    return !m_s;
      2'd1:    return m_sd && !m_s;
      2'd2:    return m_s;
      default: return !m_sd && m_s;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ff1 <= 1; m_s <= 1; m_sd <= 1; m_pend <= 0; m_en <= 0; m_irq <= 0; m_ctrl <= 0;
    end else begin
      m_irq <= m_pend && m_en;
      if (bus_we && bus_addr == 8'h04 && bus_wdata[0]) m_pend <= 0;
      else if (m_event())                               m_pend <= 1;
      if (bus_we && bus_addr == 8'h00) m_ctrl <= bus_wdata;
      if (bus_we && bus_addr == 8'h08) m_en <= bus_wdata[0];
      m_ff1 <= line_in; m_s <= m_ff1; m_sd <= m_s;
    end
  end

  function automatic bit [31:0] m_rdata(input bit [7:0] a);
    case (a)
      8'h00:   return m_ctrl;
      8'h04:   return {31'd0, m_pend};
      8'h08:   return {31'd0, m_en};
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #5;
    if (rst_n && !done) begin
      chk("R9 irq_out vs model", {31'd0, irq_a}, {31'd0, m_irq});
      chk("R2 R10 readback vs model", rdata_a, m_rdata(bus_addr));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<20000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic wr(input bit [7:0] a, input bit [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic peek(input bit [7:0] a);
    bus_addr = a;
    #1;
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    line_in = 1'b1; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; rst_n = 1'b0;
    waitn(3);
    rst_n = 1'b1;
    waitn(1);

    // R1 reset state
    peek(8'h00); chk("R1 ctrl after reset", rdata_a, 0);
    peek(8'h04); chk("R1 pend after reset", rdata_a, 0);
    peek(8'h08); chk("R1 en after reset", rdata_a, 0);
    chk("R1 irq after reset", {31'd0, irq_a}, 0);

    // R2 full word store, type 0
    wr(8'h00, 32'hC0FFEE00);
    peek(8'h00); chk("R2 ctrl readback", rdata_a, 32'hC0FFEE00);

    // bring-up: mask, then flush
    wr(8'h08, 0); wr(8'h04, 1); wr(8'h08, 1);

    // R3 latency, R4 low level
    line_in = 1'b0; peek(8'h04);
    waitn(2); chk("R3 no event before third edge", rdata_a, 0);
    waitn(1); chk("R4 low level sets pending", rdata_a, 1);
    chk("R9 irq lags pending", {31'd0, irq_a}, 0);
    waitn(1); chk("R9 irq follows pending", {31'd0, irq_a}, 1);

    // R8 level re-set, write of zero ignored
    wr(8'h04, 0); chk("R8 write zero keeps pending", rdata_a, 1);
    wr(8'h04, 1); chk("R8 clear takes effect", rdata_a, 0);
    waitn(1); chk("R8 active level sets again", rdata_a, 1);

    line_in = 1'b1; waitn(3); wr(8'h04, 1); waitn(3);
    chk("R4 high line raises nothing", rdata_a, 0);

    // R5 falling edge
    wr(8'h00, 32'hC0FFEE01);
    peek(8'h00); chk("R2 type change keeps upper bits", rdata_a, 32'hC0FFEE01);
    peek(8'h04);
    line_in = 1'b0; waitn(3); chk("R5 falling edge sets", rdata_a, 1);
    line_in = 1'b1; waitn(3); chk("R5 stays pending", rdata_a, 1);
    wr(8'h04, 1); waitn(4); chk("R5 rising ignored", rdata_a, 0);

    // R9 masking
    line_in = 1'b0; waitn(4);
    chk("R9 pending before mask", rdata_a, 1);
    chk("R9 irq before mask", {31'd0, irq_a}, 1);
    wr(8'h08, 0); waitn(1);
    chk("R9 mask drops irq", {31'd0, irq_a}, 0);
    peek(8'h04); chk("R9 mask keeps pending", rdata_a, 1);
    wr(8'h08, 1); waitn(1);
    chk("R9 unmask restores irq", {31'd0, irq_a}, 1);

    // R6 high level (line currently low)
    wr(8'h00, 32'hC0FFEE02); wr(8'h04, 1); peek(8'h04);
    waitn(3); chk("R6 low line raises nothing", rdata_a, 0);
    line_in = 1'b1; waitn(3); chk("R6 high level sets", rdata_a, 1);
    wr(8'h04, 1); chk("R6 clear", rdata_a, 0);
    waitn(1); chk("R8 high level sets again", rdata_a, 1);

    // R7 rising edge
    line_in = 1'b0;
    wr(8'h00, 32'hC0FFEE03); waitn(3); wr(8'h04, 1); peek(8'h04);
    waitn(3); chk("R7 falling ignored", rdata_a, 0);
    line_in = 1'b1; waitn(3); chk("R7 rising sets", rdata_a, 1);

    // R8 clear meets event on the same edge
    wr(8'h04, 1); line_in = 1'b0; waitn(3);
    line_in = 1'b1; waitn(2);
    wr(8'h04, 1);
    waitn(3); chk("R8 clear wins over same-cycle edge", rdata_a, 0);

    // R11 unmapped offset
    wr(8'h10, 32'hFFFFFFFF);
    peek(8'h10); chk("R11 unmapped reads zero", rdata_a, 0);
    peek(8'h00); chk("R11 ctrl untouched", rdata_a, 32'hC0FFEE03);
    peek(8'h08); chk("R11 en untouched", rdata_a, 1);
    peek(8'h04); chk("R11 pend untouched", rdata_a, 0);

    // R10 layouts, from a fresh reset
    rst_n = 1'b0; waitn(2); rst_n = 1'b1; waitn(1);
    wr(8'h08, 1); peek(8'h08);
    chk("R10 layout0 en at 08", rdata_a, 1);
    chk("R10 layout1 pend at 08", rdata_b, 0);
    chk("R10 layout2 08 unmapped", rdata_c, 0);
    wr(8'h34, 1); peek(8'h34);
    chk("R10 layout0 34 unmapped", rdata_a, 0);
    chk("R10 layout2 en at 34", rdata_c, 1);
    peek(8'h04); chk("R10 layout1 en at 04 still 0", rdata_b, 0);
    wr(8'h04, 1); peek(8'h04);
    chk("R10 layout1 en at 04", rdata_b, 1);
    line_in = 1'b0; waitn(3);
    peek(8'h08);
    chk("R10 layout1 pend at 08", rdata_b, 1);
    peek(8'h04);
    chk("R10 layout0 pend at 04", rdata_a, 1);
    chk("R10 layout2 pend at 04", rdata_c, 1);
    waitn(2);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule